// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block takes in bytes from one idle-high asynchronous serial line. A falling line marks a possible start bit. The receiver checks that start bit a second time at the middle of its bit period, so that a short low glitch is thrown away. It then samples eight data bits, least significant bit first. When parity is enabled, it also samples one parity bit, and after that the stop bit. All samples are taken at the centre of their bit periods. Timing comes from an oversampling clock enable, `os_tick`, which pulses a fixed number of times per bit period (eight by default).

A finished byte goes into a holding register, and the holding-full flag is set. Error conditions are reported in the three top bits of a status byte, and these three bits together form a single error mask. A separate bit shows that a frame is in progress. Software reads the byte and pulses `rd_stb`. This empties the register and clears all error flags. When a stop bit has been sampled, the receiver goes straight back to hunting for the next start bit, so frames can follow each other with no idle gap.

Top module: `serial_rx`

## Requirements
- R1: After reset, `status` and `rx_data` are 0. A line held high produces no byte.
- R2: A low level is taken as a start bit only if the line is still low at the middle of the bit period (OVS/2 ticks after detection). A shorter low pulse produces no byte, and the receiver goes back to idle.
- R3: The data bits are assembled LSB first. Once the stop bit has been sampled, the byte appears on `rx_data` and status bit 3 (holding full) is set.
- R4: Status bit 0 is high from start detection until the stop bit is sampled.
- R5: When `par_en` is 1, a parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity, counted over the data and parity bits together. A mismatch sets status bit 7.
- R6: If the stop bit samples as 0, status bit 5 (framing error) is set. The byte is still stored.
- R7: If a byte completes while holding full is set, status bit 6 (overrun) is set. The older byte and its flags are kept.
- R8: A one-cycle pulse on `rd_stb` clears status bits 3, 5, 6 and 7. `rx_data` keeps its value.
- R9: While `en` is 0, any frame in progress is aborted, bit 0 drops on the next cycle, and line activity produces no byte.
- R10: Status bits 7..5 form the error mask 0xE0. Bits 4, 2 and 1 always read 0. An error flag is never set while holding full is clear.
- R11: After the stop sample, the receiver hunts for a start bit at once. A start bit that directly follows a stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Receiver enable |
| os_tick | input | 1 | Oversampling enable, OVS pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_stb | input | 1 | Read strobe, pops the holding register |
| rx_data | output | 8 | Holding register contents |
| status | output | 8 | {par_err, overrun, frame_err, 0, full, 0, 0, active} |

## Verification
The assertions assume the following about the inputs:
- `os_tick` is a single-cycle pulse.
- `rd_stb` lasts one cycle.
- The line is stable for a whole bit period of OVS ticks.

The bench meets these assumptions in three ways:
- It generates `os_tick` every second clock.
- It changes `rxd` only at bit-period boundaries counted in clocks.
- It strobes reads only after a frame has finished.

The bench latches `par_en` and `par_odd` before each start bit. The receiver also captures them at start detection, so changing them inside a frame cannot disturb it.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  // bit positions inside the status byte
  localparam int ST_ACTIVE = 0;
  localparam int ST_FULL   = 3;
  localparam int ST_FRAME  = 5;
  localparam int ST_OVR    = 6;
  localparam int ST_PAR    = 7;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= din;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS    = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] frame_byte,
  output logic              frame_err,
  output logic              par_err
);
  localparam int CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int HALF  = OVS / 2;

  function automatic logic parity_mismatch(input logic [DATA_W-1:0] d,
                                           input logic pb, input logic odd);
    return ((^d) ^ pb) != odd;
  endfunction

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              cfg_par, cfg_odd;

  // named events for assertions and readability
  logic start_seen, mid_hit, centre_hit, last_data;
  assign start_seen = en && tick && (state == RX_IDLE) && !line;
  assign mid_hit    = tick && (cnt == CNT_W'(HALF - 1));
  assign centre_hit = tick && (cnt == CNT_W'(OVS - 1));
  assign last_data  = (idx == IDX_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      cfg_par    <= 1'b0;
      cfg_odd    <= 1'b0;
      done       <= 1'b0;
      frame_byte <= '0;
      frame_err  <= 1'b0;
      par_err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          RX_IDLE: begin
            if (start_seen) begin
              state   <= RX_START;
              cnt     <= '0;
              cfg_par <= par_en;
              cfg_odd <= par_odd;
            end
          end
          RX_START: begin
            if (mid_hit) begin
              cnt <= '0;
              idx <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (centre_hit) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_W-1:1]};
              if (last_data) state <= cfg_par ? RX_PAR : RX_STOP;
              else           idx   <= idx + 1'b1;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (centre_hit) begin
              cnt   <= '0;
              pbit  <= line;
              state <= RX_STOP;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (centre_hit) begin
              cnt        <= '0;
              done       <= 1'b1;
              frame_byte <= shreg;
              frame_err  <= !line;
              par_err    <= cfg_par && parity_mismatch(shreg, pbit, cfg_odd);
              state      <= RX_IDLE;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign active = (state != RX_IDLE);

  AST_EN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !active); // R9
  AST_DONE_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active); // R11
  AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> active); // R4
  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == RX_START && mid_hit && line) |=> !active); // R2
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              frame_err,
  input  logic              par_err,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] hold_data,
  output logic              full,
  output logic              ferr_q,
  output logic              perr_q,
  output logic              ovr_q
);
  // a read in the same cycle as a completion frees the register first
  logic full_eff, accept, overrun_ev;
  assign full_eff   = full && !rd_stb;
  assign accept     = done && !full_eff;
  assign overrun_ev = done && full_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data <= '0;
      full      <= 1'b0;
      ferr_q    <= 1'b0;
      perr_q    <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (rd_stb) begin
        full   <= 1'b0;
        ferr_q <= 1'b0;
        perr_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (accept) begin
        hold_data <= frame_byte;
        full      <= 1'b1;
        ferr_q    <= frame_err;
        perr_q    <= par_err;
      end
      if (overrun_ev) ovr_q <= 1'b1;
    end
  end

  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !rd_stb) |=> ($stable(hold_data) && ovr_q)); // R7
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !done) |=> (!full && !ferr_q && !perr_q && !ovr_q)); // R8
  AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> full); // R3
  AST_FLAG_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_q || perr_q || ovr_q) |-> full); // R10
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import srx_pkg::*;
#(
  parameter int OVS       = 8,
  parameter int DATA_W    = 8,
  parameter int SYNC_FLOP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic [7:0]        status
);
  logic line_s;
  logic active, done, frame_err, par_err;
  logic [DATA_W-1:0] frame_byte;
  logic full, ferr_q, perr_q, ovr_q;

  srx_sync #(.STAGES(SYNC_FLOP)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  srx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(os_tick), .line(line_s),
    .par_en(par_en), .par_odd(par_odd), .active(active), .done(done),
    .frame_byte(frame_byte), .frame_err(frame_err), .par_err(par_err)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .done(done), .frame_byte(frame_byte),
    .frame_err(frame_err), .par_err(par_err), .rd_stb(rd_stb),
    .hold_data(rx_data), .full(full), .ferr_q(ferr_q), .perr_q(perr_q),
    .ovr_q(ovr_q)
  );

  always_comb begin
    status            = 8'h00;
    status[ST_ACTIVE] = active;
    status[ST_FULL]   = full;
    status[ST_FRAME]  = ferr_q;
    status[ST_OVR]    = ovr_q;
    status[ST_PAR]    = perr_q;
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'h16) == 8'h00); // R10
endmodule

// File: tb/serial_rx_test.sv
module serial_rx_test;
  localparam int OVS      = 8;
  localparam int TICK_DIV = 2;
  localparam int BIT_CLK  = OVS * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, os_tick = 1'b0, rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, rd_stb = 1'b0;
  logic [7:0] rx_data, status;

  int checks = 0, errors = 0, tdiv = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV - 1);
  end

  serial_rx uut (
    .clk(clk), .rst_n(rst_n), .en(en), .os_tick(os_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb),
    .rx_data(rx_data), .status(status)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return ((ones % 2) == 1) ? !odd : odd;  // makes total count even/odd
  endfunction

  task automatic send(input logic [7:0] d, input logic use_par,
                      input logic pv, input logic stopv);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    if (use_par) bit_out(pv);
    bit_out(stopv);
  endtask

  task automatic rd();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    chk("R1 status after reset", status, 8'h00);
    chk("R1 data after reset", rx_data, 8'h00);

    // R3/R11: every byte, no parity, frames back to back
    for (int v = 0; v < 256; v++) begin
      send(v[7:0], 1'b0, 1'b0, 1'b1);
      chk("R3 byte", rx_data, v[7:0]);
      chk("R11 status back-to-back", status, 8'h08);
      rd();
    end
    bit_out(1'b1);

    // R5: even parity on all bytes
    par_en = 1'b1; par_odd = 1'b0;
    for (int v = 0; v < 256; v++) begin
      send(v[7:0], 1'b1, par_bit(v[7:0], 1'b0), 1'b1);
      chk("R5 even byte", rx_data, v[7:0]);
      chk("R5 even status", status, 8'h08);
      rd();
    end
    // R5: odd parity, every fourth frame with a wrong parity bit
    par_odd = 1'b1;
    for (int v = 0; v < 64; v++) begin
      logic [7:0] d;
      logic bad;
      d   = 8'(v * 37 + 5);
      bad = (v % 4 == 0);
      send(d, 1'b1, par_bit(d, 1'b1) ^ bad, 1'b1);
      chk("R5 odd byte", rx_data, d);
      chk("R5 odd status", status, bad ? 8'h88 : 8'h08);
      rd();
    end
    par_en = 1'b0; par_odd = 1'b0;
    bit_out(1'b1);

    // R8: read clears flags, data stays
    chk("R8 cleared status", status, 8'h00);
    chk("R8 data kept", rx_data, 8'(63 * 37 + 5));

    // R6: framing error, byte still stored
    send(8'hC3, 1'b0, 1'b0, 1'b0);
    bit_out(1'b1); bit_out(1'b1);
    chk("R6 framing byte", rx_data, 8'hC3);
    chk("R6 framing status", status, 8'h28);
    rd();

    // R10: parity + framing combine inside the error mask
    par_en = 1'b1;
    send(8'h01, 1'b1, 1'b0, 1'b0);
    bit_out(1'b1); bit_out(1'b1);
    chk("R10 error mask", status & 8'hE0, 8'hA0);
    chk("R10 zero bits", status & 8'h16, 8'h00);
    rd();
    par_en = 1'b0;

    // R7: overrun keeps the older byte
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R7 older byte kept", rx_data, 8'h5A);
    chk("R7 overrun status", status, 8'h48);
    rd();
    chk("R8 overrun cleared", status, 8'h00);

    // R2: short low glitch rejected
    rxd = 1'b0;
    repeat (2 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    chk("R2 glitch no byte", status, 8'h00);
    chk("R2 glitch data", rx_data, 8'h5A);

    // R4: active flag mid-frame, clear afterwards
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    chk("R4 active mid-frame", status, 8'h01);
    for (int i = 2; i < 8; i++) bit_out(1'b1);
    bit_out(1'b1);
    chk("R4 inactive after stop", status & 8'h01, 8'h00);
    chk("R3 partial pattern", rx_data, 8'hFD);
    rd();

    // R9: drop enable mid-frame, then frames ignored while disabled
    bit_out(1'b0); bit_out(1'b0);
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 abort active", status, 8'h00);
    for (int i = 1; i < 8; i++) bit_out(1'b0);
    bit_out(1'b1);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    bit_out(1'b1);
    chk("R9 disabled status", status, 8'h00);
    chk("R9 disabled data", rx_data, 8'hFD);
    en = 1'b1;
    bit_out(1'b1);
    send(8'h96, 1'b0, 1'b0, 1'b1);
    chk("R9 re-enabled byte", rx_data, 8'h96);
    chk("R1 idle line no extra byte", status, 8'h08);
    rd();

    report();
  end
endmodule